// File: doc/BRIEF.md
# Doorbell Mailbox Register Window

This block gives a host a small memory-mapped window through which it submits one command at a time to a device-side handler. The host places an opcode, a command-set number and an input length in the command register, loads input bytes into a 2048-byte payload area, and then sets the doorbell bit in the control register. From that point the block owns the exchange. It copies the payload into a snapshot store and zeroes the live payload. It then offers the command to a back-end handler through a valid/ready request. When the handler responds, the block writes the result length and status back in one step and drops the doorbell.

The host reaches everything through a simple bus of 1, 2, 4 or 8-byte accesses. Each access must be naturally aligned. Data is little-endian and sits on the byte lanes given by the low address bits. Reads return the whole 64-bit word one cycle after the request. The handler reads its input from the snapshot through a word read port. It places its output directly in the payload through a word write port. Progress of a background task is fed in from outside, and an 8-byte read of the background word assembles that progress live.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the capability word (offset 0x00, bits 4:0) reads 11, which is log2 of the 2048-byte payload. The doorbell (offset 0x04, bit 0, seen at bus bit 32), the command word and the status word read zero. No request is offered.
- R2: Aligned writes of any width between 0x20 and 0x81F update only the addressed bytes of the payload, but only while no command is in flight. The lane of each byte is address bits 2:0.
- R3: Below 0x20, only three writes take effect: a 4-byte write at 0x04, and 8-byte writes at 0x08 (command) and 0x18 (background word). All other writes are ignored, including writes to the capability word, narrower writes to the command word, and writes at or above 0x820.
- R4: Any write to the status word (offset 0x10) is discarded.
- R5: A 4-byte control write with bit 0 set while idle raises the doorbell. It then offers the handler the opcode (command bits 7:0), the command set (bits 15:8) and the input length (bits 36:16), and holds them until the handler accepts.
- R6: When the doorbell rings, the handler's read port sees the previous payload contents. The host-visible payload reads zero until the handler writes it.
- R7: On the handler response, three updates happen on the same edge. The command word becomes the output length in bits 36:16 with the same set and opcode. The status word becomes the return code in bits 47:32 with the background-start flag in bit 0. The doorbell clears.
- R8: An 8-byte read of 0x18 returns the background opcode in bits 15:0, the percent complete in bits 22:16 and the background return code in bits 47:32, all taken live. That value is also stored, and narrower reads of 0x18 return the stored value.
- R9: An 8-byte status read while percent complete is nonzero clears status bit 0, and that read already returns the cleared bit. Narrower reads, and reads while percent complete is zero, leave the bit unchanged.
- R10: A write whose address is not a multiple of its width has no effect.
- R11: While the doorbell is set, host writes to the command word and to the payload are ignored.
- R12: If a clearing status read falls on the same edge as a handler response, the response's status is kept. The read returns the status as it stood before the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | AW | Byte address within the window |
| bus_size | input | 2 | Access width: 0=1B, 1=2B, 2=4B, 3=8B |
| bus_wdata | input | 64 | Lane-aligned write data |
| bus_rdata | output | 64 | Addressed 64-bit word, one cycle after the read |
| hreq_valid | output | 1 | Command offered to the handler |
| hreq_ready | input | 1 | Handler accepts the command |
| hreq_set | output | 8 | Command set |
| hreq_op | output | 8 | Opcode |
| hreq_len | output | LEN_W | Input length in bytes |
| hin_addr | input | WI_W | Snapshot word index |
| hin_data | output | 64 | Snapshot word |
| hout_we | input | 1 | Handler payload write |
| hout_addr | input | WI_W | Payload word index for the handler write |
| hout_data | input | 64 | Payload word from the handler |
| hrsp_valid | input | 1 | Handler response |
| hrsp_rc | input | RC_W | Return code |
| hrsp_len | input | LEN_W | Output length |
| hrsp_bg | input | 1 | Handler started a background task |
| bg_op | input | 16 | Background opcode |
| bg_pct | input | 7 | Background percent complete |
| bg_rc | input | 16 | Background return code |

## Verification
The status word has two writers. A handler response rewrites it, and an 8-byte host read clears its background bit when progress is nonzero. Both can land on the same clock edge. The bench forces this case. It drives the status read in the very cycle it raises the handler response, with percent complete held nonzero. It then checks two things: the data returned by that read shows the old status with bit 0 cleared, and a later read with progress at zero still shows the new return code and a set background bit.

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int PAYLOAD_SHIFT = 11,
  parameter int AW = 12,
  parameter int LEN_W = 21,
  parameter int RC_W = 16,
  localparam int WI_W = PAYLOAD_SHIFT - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [63:0]      bus_wdata,
  output logic [63:0]      bus_rdata,
  output logic             hreq_valid,
  input  logic             hreq_ready,
  output logic [7:0]       hreq_set,
  output logic [7:0]       hreq_op,
  output logic [LEN_W-1:0] hreq_len,
  input  logic [WI_W-1:0]  hin_addr,
  output logic [63:0]      hin_data,
  input  logic             hout_we,
  input  logic [WI_W-1:0]  hout_addr,
  input  logic [63:0]      hout_data,
  input  logic             hrsp_valid,
  input  logic [RC_W-1:0]  hrsp_rc,
  input  logic [LEN_W-1:0] hrsp_len,
  input  logic             hrsp_bg,
  input  logic [15:0]      bg_op,
  input  logic [6:0]       bg_pct,
  input  logic [15:0]      bg_rc
);
  localparam int PL_BYTES = 1 << PAYLOAD_SHIFT;
  localparam int PL_WORDS = PL_BYTES / 8;
  localparam logic [AW-1:0] OFS_CAP  = AW'(0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(4);
  localparam logic [AW-1:0] OFS_CMD  = AW'(8);
  localparam logic [AW-1:0] OFS_STS  = AW'(16);
  localparam logic [AW-1:0] OFS_BG   = AW'(24);
  localparam logic [AW-1:0] PL_BASE  = AW'(32);
  localparam logic [AW-1:0] PL_END   = PL_BASE + AW'(PL_BYTES);
  localparam logic [31:0]   CAP_VAL  = 32'(PAYLOAD_SHIFT);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t         st_q;
  logic        db_q;
  logic [63:0] cmd_q, sts_q, bg_q;
  logic [63:0] pay  [PL_WORDS];
  logic [63:0] snap [PL_WORDS];

  logic [7:0]      be_base, be;
  logic            aligned, in_pl, wr_ok, rd_ok;
  logic            hw_cmd, hw_bg, ring, hw_pl, done, rd_sts8, rd_bg8, sts_clr;
  logic [WI_W-1:0] pl_idx;
  logic [63:0]     live_bg, rd_word;

  always_comb begin
    case (bus_size)
      2'd0:    be_base = 8'h01;
      2'd1:    be_base = 8'h03;
      2'd2:    be_base = 8'h0F;
      default: be_base = 8'hFF;
    endcase
  end

  assign be      = be_base << bus_addr[2:0];
  assign aligned = (bus_addr[2:0] & ((3'd1 << bus_size) - 3'd1)) == 3'd0;
  assign in_pl   = (bus_addr >= PL_BASE) && (bus_addr < PL_END);
  assign pl_idx  = WI_W'((bus_addr - PL_BASE) >> 3);
  assign wr_ok   = bus_wr && aligned;
  assign rd_ok   = bus_rd && aligned;
  assign hw_cmd  = wr_ok && !db_q && bus_size == 2'd3 && bus_addr == OFS_CMD;
  assign hw_bg   = wr_ok && bus_size == 2'd3 && bus_addr == OFS_BG;
  assign ring    = wr_ok && !db_q && bus_size == 2'd2 && bus_addr == OFS_CTRL && bus_wdata[32];
  assign hw_pl   = wr_ok && !db_q && in_pl;
  assign done    = st_q == S_WAIT && hrsp_valid;
  assign rd_sts8 = rd_ok && bus_size == 2'd3 && bus_addr == OFS_STS;
  assign rd_bg8  = rd_ok && bus_size == 2'd3 && bus_addr == OFS_BG;
  assign sts_clr = rd_sts8 && bg_pct != 7'd0;
  assign live_bg = {16'd0, bg_rc, 9'd0, bg_pct, bg_op};

  assign hreq_valid = st_q == S_ISSUE;
  assign hreq_op    = cmd_q[7:0];
  assign hreq_set   = cmd_q[15:8];
  assign hreq_len   = cmd_q[16 +: LEN_W];
  assign hin_data   = snap[hin_addr];

  always_comb begin
    rd_word = '0;
    if (in_pl) rd_word = pay[pl_idx];
    else begin
      case (bus_addr[AW-1:3])
        OFS_CAP[AW-1:3]: rd_word = {31'd0, db_q, CAP_VAL};
        OFS_CMD[AW-1:3]: rd_word = cmd_q;
        OFS_STS[AW-1:3]: rd_word = sts_clr ? {sts_q[63:1], 1'b0} : sts_q;
        OFS_BG[AW-1:3]:  rd_word = rd_bg8 ? live_bg : bg_q;
        default:         rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      db_q <= 1'b0;
      cmd_q <= '0;
      sts_q <= '0;
      bg_q <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_ok ? rd_word : '0;
      if (hw_cmd) cmd_q <= bus_wdata;
      if (hw_bg) bg_q <= bus_wdata;
      if (rd_bg8) bg_q <= live_bg;
      if (sts_clr) sts_q[0] <= 1'b0;
      case (st_q)
        S_IDLE: if (ring) begin
          db_q <= 1'b1;
          st_q <= S_ISSUE;
        end
        S_ISSUE: if (hreq_ready) st_q <= S_WAIT;
        S_WAIT: if (hrsp_valid) begin
          cmd_q <= {{(48 - LEN_W){1'b0}}, hrsp_len, cmd_q[15:0]};
          sts_q <= {{(32 - RC_W){1'b0}}, hrsp_rc, 31'd0, hrsp_bg};
          db_q  <= 1'b0;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ring) for (int i = 0; i < PL_WORDS; i++) snap[i] <= pay[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ring) begin
      for (int i = 0; i < PL_WORDS; i++) pay[i] <= '0;
    end else begin
      if (hw_pl)
        for (int b = 0; b < 8; b++)
          if (be[b]) pay[pl_idx][8*b +: 8] <= bus_wdata[8*b +: 8];
      if (hout_we && st_q == S_WAIT) pay[hout_addr] <= hout_data;
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid && !hreq_ready |=> hreq_valid && $stable(hreq_op) && $stable(hreq_set) && $stable(hreq_len));

  p_db_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !db_q && !hreq_valid);

  p_sts_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_STS && !bus_rd && !done |=> $stable(sts_q));

  p_busy_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    db_q && bus_wr && bus_addr == OFS_CMD && !done |=> $stable(cmd_q));

  p_sts_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr && !done |=> !sts_q[0]);

  p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sts_q[0] == $past(hrsp_bg));
endmodule

// File: tb/mbox_ctrl_bench.sv
module mbox_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic        hreq_valid, hreq_ready = 1'b0;
  logic [7:0]  hreq_set, hreq_op;
  logic [20:0] hreq_len;
  logic [7:0]  hin_addr = '0, hout_addr = '0;
  logic [63:0] hin_data, hout_data = '0;
  logic        hout_we = 1'b0, hrsp_valid = 1'b0, hrsp_bg = 1'b0;
  logic [15:0] hrsp_rc = '0;
  logic [20:0] hrsp_len = '0;
  logic [15:0] bg_op = '0, bg_rc = '0;
  logic [6:0]  bg_pct = '0;

  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  mbox_ctrl u_mbox_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_set(hreq_set),
    .hreq_op(hreq_op), .hreq_len(hreq_len),
    .hin_addr(hin_addr), .hin_data(hin_data),
    .hout_we(hout_we), .hout_addr(hout_addr), .hout_data(hout_data),
    .hrsp_valid(hrsp_valid), .hrsp_rc(hrsp_rc), .hrsp_len(hrsp_len), .hrsp_bg(hrsp_bg),
    .bg_op(bg_op), .bg_pct(bg_pct), .bg_rc(bg_rc)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [11:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd3, 12'h000, 64'h0, 64'h0000_0000_0000_000B, 4'd1},              // R1
    '{1'b0, 2'd3, 12'h008, 64'h0, 64'h0, 4'd1},                                // R1
    '{1'b0, 2'd3, 12'h010, 64'h0, 64'h0, 4'd1},                                // R1
    '{1'b1, 2'd3, 12'h020, 64'h1122_3344_5566_7788, 64'h0, 4'd2},              // R2
    '{1'b0, 2'd3, 12'h020, 64'h0, 64'h1122_3344_5566_7788, 4'd2},              // R2
    '{1'b1, 2'd0, 12'h023, 64'h0000_0000_AA00_0000, 64'h0, 4'd2},              // R2
    '{1'b0, 2'd3, 12'h020, 64'h0, 64'h1122_3344_AA66_7788, 4'd2},              // R2
    '{1'b1, 2'd1, 12'h026, 64'hBEEF_0000_0000_0000, 64'h0, 4'd2},              // R2
    '{1'b0, 2'd3, 12'h020, 64'h0, 64'hBEEF_3344_AA66_7788, 4'd2},              // R2
    '{1'b1, 2'd2, 12'h02C, 64'hCAFE_F00D_0000_0000, 64'h0, 4'd2},              // R2
    '{1'b0, 2'd3, 12'h028, 64'h0, 64'hCAFE_F00D_0000_0000, 4'd2},              // R2
    '{1'b1, 2'd1, 12'h021, 64'h0000_0000_00FF_FF00, 64'h0, 4'd10},             // R10
    '{1'b0, 2'd3, 12'h020, 64'h0, 64'hBEEF_3344_AA66_7788, 4'd10},             // R10
    '{1'b1, 2'd3, 12'h000, 64'hFFFF_FFFE_FFFF_FFFF, 64'h0, 4'd3},              // R3
    '{1'b1, 2'd2, 12'h000, 64'h0000_0000_FFFF_FFFF, 64'h0, 4'd3},              // R3
    '{1'b0, 2'd3, 12'h000, 64'h0, 64'h0000_0000_0000_000B, 4'd3},              // R3
    '{1'b1, 2'd2, 12'h008, 64'h0000_0000_1234_5678, 64'h0, 4'd3},              // R3
    '{1'b0, 2'd3, 12'h008, 64'h0, 64'h0, 4'd3},                                // R3
    '{1'b1, 2'd3, 12'h008, 64'h0000_0000_0004_0201, 64'h0, 4'd3},              // R3
    '{1'b0, 2'd3, 12'h008, 64'h0, 64'h0000_0000_0004_0201, 4'd3},              // R3
    '{1'b1, 2'd3, 12'h010, 64'h0000_FFFF_0000_FFFF, 64'h0, 4'd4},              // R4
    '{1'b0, 2'd3, 12'h010, 64'h0, 64'h0, 4'd4},                                // R4
    '{1'b1, 2'd3, 12'h018, 64'h0000_0000_0000_1234, 64'h0, 4'd3},              // R3
    '{1'b0, 2'd2, 12'h018, 64'h0, 64'h0000_0000_0000_1234, 4'd8},              // R8
    '{1'b1, 2'd3, 12'h818, 64'h0102_0304_0506_0708, 64'h0, 4'd2},              // R2
    '{1'b0, 2'd3, 12'h818, 64'h0, 64'h0102_0304_0506_0708, 4'd2}               // R2
  };

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [1:0] s, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_chk(input int req, input logic [11:0] a, input logic [1:0] s, input logic [63:0] exp);
    logic [63:0] d;
    bus_read(a, s, d);
    chk(req, d, exp);
  endtask

  task automatic accept_req(input logic [7:0] op, input logic [7:0] set, input logic [20:0] len);
    for (int n = 0; n < 20 && !hreq_valid; n++) @(negedge clk);
    chk(5, {63'd0, hreq_valid}, 64'd1);
    chk(5, {40'd0, hreq_len, hreq_set, hreq_op}, {40'd0, len, set, op});
    hreq_ready = 1'b1;
    @(negedge clk);
    hreq_ready = 1'b0;
  endtask

  task automatic finish_cmd(input logic [15:0] rc, input logic [20:0] len, input logic bg,
                            input logic [63:0] outw, input logic collide, output logic [63:0] coll);
    repeat (3) @(negedge clk);
    hout_we = 1'b1; hout_addr = 8'd0; hout_data = outw;
    @(negedge clk);
    hout_we = 1'b0;
    hrsp_valid = 1'b1; hrsp_rc = rc; hrsp_len = len; hrsp_bg = bg;
    if (collide) begin
      bus_rd = 1'b1; bus_addr = 12'h010; bus_size = 2'd3;
    end
    @(negedge clk);
    hrsp_valid = 1'b0; bus_rd = 1'b0;
    coll = bus_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {63'd0, hreq_valid}, 64'd0);           // R1

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].sz, VEC[i].data);
      else read_chk(int'(VEC[i].req), VEC[i].addr, VEC[i].sz, VEC[i].exp);
    end

    // R5 R6 R11: first command, checked while in flight
    bus_write(12'h008, 2'd3, 64'h0000_0000_0008_0742);
    bus_write(12'h004, 2'd2, 64'h0000_0001_0000_0000);
    accept_req(8'h42, 8'h07, 21'd8);
    hin_addr = 8'd0;
    #1;
    chk(6, hin_data, 64'hBEEF_3344_AA66_7788);     // R6 snapshot
    read_chk(6, 12'h020, 2'd3, 64'h0);             // R6 cleared
    read_chk(5, 12'h000, 2'd3, 64'h0000_0001_0000_000B); // R5 doorbell up
    bus_write(12'h008, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    read_chk(11, 12'h008, 2'd3, 64'h0000_0000_0008_0742); // R11
    bus_write(12'h028, 2'd3, 64'h5555_5555_5555_5555);
    read_chk(11, 12'h028, 2'd3, 64'h0);            // R11
    finish_cmd(16'h0003, 21'h10, 1'b1, 64'h55AA, 1'b0, d);

    // R7 results
    read_chk(7, 12'h000, 2'd3, 64'h0000_0000_0000_000B);
    read_chk(7, 12'h008, 2'd3, 64'h0000_0000_0010_0742);
    read_chk(7, 12'h010, 2'd3, 64'h0000_0003_0000_0001);
    read_chk(7, 12'h020, 2'd3, 64'h0000_0000_0000_55AA);

    // R9 status clear on 8-byte read with progress
    bg_op = 16'h0044; bg_pct = 7'd50; bg_rc = 16'h0007;
    read_chk(9, 12'h010, 2'd2, 64'h0000_0003_0000_0001);
    read_chk(9, 12'h010, 2'd3, 64'h0000_0003_0000_0000);
    read_chk(9, 12'h010, 2'd3, 64'h0000_0003_0000_0000);

    // R8 live background word, then stored
    read_chk(8, 12'h018, 2'd3, 64'h0000_0007_0032_0044);
    bg_op = '0; bg_rc = '0;
    read_chk(8, 12'h018, 2'd2, 64'h0000_0007_0032_0044);

    // R12 response and clearing read on the same edge
    bg_pct = 7'd10;
    bus_write(12'h008, 2'd3, 64'h0000_0000_0000_0101);
    bus_write(12'h004, 2'd2, 64'h0000_0001_0000_0000);
    accept_req(8'h01, 8'h01, 21'd0);
    finish_cmd(16'h0009, 21'd0, 1'b1, 64'h0, 1'b1, d);
    chk(12, d, 64'h0000_0003_0000_0000);
    bg_pct = 7'd0;
    read_chk(12, 12'h010, 2'd3, 64'h0000_0009_0000_0001);
    read_chk(7, 12'h000, 2'd3, 64'h0000_0000_0000_000B);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule